// File: doc/BRIEF.md
# Serial-Programmed Configuration Byte Writer

This block is the target-side half of a two-wire serial programming port. A programmer toggles a serial clock and presents data on a second wire. Each transaction carries 20 bits: a 4-bit command, then a 16-bit payload. The block oversamples both wires with the system clock. It understands two commands. One executes a small subset of core instructions that load a 22-bit table pointer. The other writes through that pointer and starts a programming cycle.

When the pointer falls inside the configuration space, a table write commits exactly one byte of the payload into a small configuration byte array. The parity of the pointer picks which payload byte is stored. The block then holds a busy phase of fixed length, standing in for the programming delay. One configuration bit, once cleared, locks every later configuration write, and it can lock itself. A second bit guards the boot-block window at the bottom of the address space. Writes accepted in that window leave as a one-cycle strobe toward an external program-memory writer. Illegal writes raise a sticky error flag.

Top module: `cfgprog_port`

## Requirements
- R1: The serial data line is sampled on each falling edge of the serial clock, least significant bit first. The first 4 bits form the command and the next 16 bits form the payload, and a frame is decoded once after every 20th falling edge.
- R2: Command 0000 runs a core instruction held in the payload. Opcode byte (payload[15:8]) 0x0E loads payload[7:0] into a working byte. Opcode 0x6E with payload[7:0] equal to 0xF8, 0xF7 or 0xF6 copies the working byte into pointer bits [21:16] (its low 6 bits), [15:8] or [7:0]. Opcode 0x2A with payload[7:0] = 0xF6 increments pointer bits [7:0] modulo 256 with no carry upward. Any other payload leaves the pointer unchanged.
- R3: Command 1111 with the pointer at configuration address 0x300000+i (i below the array size) writes payload[7:0] into byte i when the pointer is even and payload[15:8] when it is odd. The other payload byte and every other array byte are left unchanged.
- R4: Command 1111 with the pointer outside both the configuration space and the boot window (0x000000 to 0x0001FF) changes no byte, gives no strobe and sets the error flag.
- R5: Every table write that is accepted (configuration or boot window, block idle) holds busy high for exactly PROG_CYC system clock cycles.
- R6: Command 1111 that completes while busy is high is dropped: no byte and no strobe change, and the error flag is set.
- R7: When bit 5 of configuration byte 11 is 0, every later configuration write leaves the array unchanged, byte 11 included. The busy phase still runs and no error is raised.
- R8: A table write into the boot window while bit 6 of configuration byte 11 is 1 gives a one-cycle fl_we strobe with fl_addr = pointer[8:0] and fl_data = payload. While that bit is 0, no strobe is given and the error flag is set.
- R9: After reset, all configuration bytes read 0xFF, the pointer is 0, and busy and err are low. Once err is set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pgc | input | 1 | Serial programming clock (asynchronous) |
| pgd | input | 1 | Serial programming data (asynchronous) |
| rd_addr | input | AW | Configuration byte index to read |
| rd_data | output | 8 | Registered configuration byte at rd_addr |
| ptr | output | 22 | Current table pointer |
| busy | output | 1 | Programming phase in progress |
| err | output | 1 | Sticky error flag |
| fl_we | output | 1 | Boot-window write strobe |
| fl_addr | output | 9 | Boot-window byte address |
| fl_data | output | 16 | Boot-window payload |

## Verification
The checker watches four behaviours on every cycle: the exact length of each busy phase, that the error flag stays set, that frame and strobe pulses last a single cycle, and that the lock bit never releases once it has been cleared. Some behaviours only the bench's scenarios can show: which payload byte lands where under each pointer parity, the arithmetic of the pointer instructions including the low-byte wrap, that locked or dropped writes leave the array untouched, and the contents of the boot strobe.

// File: rtl/cfgprog_pkg.sv
package cfgprog_pkg;
  localparam int CMD_W = 4;
  localparam int PAY_W = 16;
  localparam int FRM_W = CMD_W + PAY_W;
  localparam int PTR_W = 22;

  localparam logic [CMD_W-1:0] CMD_CORE  = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_TBLWR = 4'b1111;

  // core instruction subset: opcode byte / argument byte
  localparam logic [7:0] OP_LIT = 8'h0E;
  localparam logic [7:0] OP_MOV = 8'h6E;
  localparam logic [7:0] OP_INC = 8'h2A;
  localparam logic [7:0] SEL_UP = 8'hF8;
  localparam logic [7:0] SEL_HI = 8'hF7;
  localparam logic [7:0] SEL_LO = 8'hF6;

  localparam logic [PTR_W-1:0] CFG_BASE = 22'h300000;

  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic [PAY_W-1:0] pay;
  } frame_t;
endpackage

// File: rtl/cfgprog_rx.sv
module cfgprog_rx
  import cfgprog_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sclk,
  input  logic   sdat,
  output logic   vld,
  output frame_t frm
);
  localparam int CW = $clog2(FRM_W);

  logic [1:0]       c_s, d_s;
  logic             c_q;
  logic [FRM_W-1:0] sh, nxt;
  logic [CW-1:0]    cnt;
  logic             fall;

  assign fall = c_q & ~c_s[1];
  assign nxt  = {d_s[1], sh[FRM_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      c_s <= '0;
      d_s <= '0;
      c_q <= 1'b0;
      sh  <= '0;
      cnt <= '0;
      vld <= 1'b0;
      frm <= '0;
    end else begin
      c_s <= {c_s[0], sclk};
      d_s <= {d_s[0], sdat};
      c_q <= c_s[1];
      vld <= 1'b0;
      if (fall) begin
        sh <= nxt;
        if (cnt == CW'(FRM_W - 1)) begin
          cnt     <= '0;
          vld     <= 1'b1;
          frm.cmd <= nxt[CMD_W-1:0];
          frm.pay <= nxt[FRM_W-1:CMD_W];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfgprog_ptr.sv
module cfgprog_ptr
  import cfgprog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_vld,
  input  logic [PAY_W-1:0] ins,
  output logic [PTR_W-1:0] ptr
);
  localparam int UP_W = PTR_W - 16;

  logic [7:0]      wreg, hi, lo;
  logic [UP_W-1:0] up;
  logic [7:0]      op, arg;

  assign op  = ins[15:8];
  assign arg = ins[7:0];
  assign ptr = {up, hi, lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      wreg <= '0;
      up   <= '0;
      hi   <= '0;
      lo   <= '0;
    end else if (ins_vld) begin
      case (op)
        OP_LIT: wreg <= arg;
        OP_MOV: begin
          case (arg)
            SEL_UP:  up <= wreg[UP_W-1:0];
            SEL_HI:  hi <= wreg;
            SEL_LO:  lo <= wreg;
            default: ;
          endcase
        end
        OP_INC: if (arg == SEL_LO) lo <= lo + 8'd1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfgprog_store.sv
module cfgprog_store #(
  parameter int NCFG      = 16,
  parameter int LOCK_IDX  = 11,
  parameter int CFG_BIT   = 5,
  parameter int BOOT_BIT  = 6,
  localparam int AW       = $clog2(NCFG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  output logic          cfg_open,
  output logic          boot_open
);
  logic [7:0] mem [NCFG];

  // small array: reset to the erased value, one write and one registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCFG; i++) mem[i] <= 8'hFF;
      rdata <= 8'hFF;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end

  // shadow of the two protect bits, kept beside the array
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_open  <= 1'b1;
      boot_open <= 1'b1;
    end else if (we && waddr == AW'(LOCK_IDX)) begin
      cfg_open  <= wdata[CFG_BIT];
      boot_open <= wdata[BOOT_BIT];
    end
  end
endmodule

// File: rtl/cfgprog_port.sv
module cfgprog_port
  import cfgprog_pkg::*;
#(
  parameter int NCFG     = 16,
  parameter int PROG_CYC = 40,
  parameter int LOCK_IDX = 11,
  parameter int CFG_BIT  = 5,
  parameter int BOOT_BIT = 6,
  parameter int BOOT_AW  = 9,
  localparam int AW      = $clog2(NCFG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pgc,
  input  logic               pgd,
  input  logic [AW-1:0]      rd_addr,
  output logic [7:0]         rd_data,
  output logic [PTR_W-1:0]   ptr,
  output logic               busy,
  output logic               err,
  output logic               fl_we,
  output logic [BOOT_AW-1:0] fl_addr,
  output logic [PAY_W-1:0]   fl_data
);
  localparam int BCW = $clog2(PROG_CYC + 1);

  logic             frm_vld;
  frame_t           frm;
  logic             wr_req, mem_we, in_cfg, in_boot;
  logic             cfg_open, boot_open;
  logic [PTR_W-1:0] off;
  logic [7:0]       wbyte;
  logic [BCW-1:0]   bcnt;

  cfgprog_rx u_rx (
    .clk (clk), .rst (rst), .sclk (pgc), .sdat (pgd),
    .vld (frm_vld), .frm (frm)
  );

  cfgprog_ptr u_ptr (
    .clk (clk), .rst (rst),
    .ins_vld (frm_vld && frm.cmd == CMD_CORE),
    .ins (frm.pay), .ptr (ptr)
  );

  assign off     = ptr - CFG_BASE;
  assign in_cfg  = off < PTR_W'(NCFG);
  assign in_boot = (ptr >> BOOT_AW) == '0;
  assign wr_req  = frm_vld && frm.cmd == CMD_TBLWR;
  assign wbyte   = ptr[0] ? frm.pay[15:8] : frm.pay[7:0];
  assign mem_we  = wr_req && !busy && in_cfg && cfg_open;

  cfgprog_store #(
    .NCFG (NCFG), .LOCK_IDX (LOCK_IDX), .CFG_BIT (CFG_BIT), .BOOT_BIT (BOOT_BIT)
  ) u_store (
    .clk (clk), .rst (rst), .we (mem_we), .waddr (off[AW-1:0]), .wdata (wbyte),
    .raddr (rd_addr), .rdata (rd_data), .cfg_open (cfg_open), .boot_open (boot_open)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bcnt    <= '0;
      err     <= 1'b0;
      fl_we   <= 1'b0;
      fl_addr <= '0;
      fl_data <= '0;
    end else begin
      fl_we <= 1'b0;
      if (busy) begin
        if (bcnt == '0) busy <= 1'b0;
        else            bcnt <= bcnt - 1'b1;
      end
      if (wr_req) begin
        if (busy) begin
          err <= 1'b1;
        end else if (in_cfg) begin
          busy <= 1'b1;
          bcnt <= BCW'(PROG_CYC - 1);
        end else if (in_boot && boot_open) begin
          busy    <= 1'b1;
          bcnt    <= BCW'(PROG_CYC - 1);
          fl_we   <= 1'b1;
          fl_addr <= ptr[BOOT_AW-1:0];
          fl_data <= frm.pay;
        end else begin
          err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfgprog_chk.sv
module cfgprog_chk #(
  parameter int PROG_CYC = 40
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic err,
  input logic fl_we,
  input logic frm_vld,
  input logic wr_req,
  input logic mem_we,
  input logic cfg_open
);
  int bc;

  always_ff @(posedge clk) begin
    if (rst) bc <= 0;
    else     bc <= busy ? bc + 1 : 0;
  end

  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (rst) frm_vld |=> !frm_vld); // R1
  AST_BUSY_LEN:    assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> bc == PROG_CYC); // R5
  AST_BUSY_MAX:    assert property (@(posedge clk) disable iff (rst) busy |-> bc < PROG_CYC); // R5
  AST_WR_BUSY:     assert property (@(posedge clk) disable iff (rst) mem_we |=> busy); // R5
  AST_DROP_ERR:    assert property (@(posedge clk) disable iff (rst) (wr_req && busy) |=> err); // R6
  AST_LOCK_HOLD:   assert property (@(posedge clk) disable iff (rst) !cfg_open |=> !cfg_open); // R7
  AST_STROBE_ONE:  assert property (@(posedge clk) disable iff (rst) fl_we |=> !fl_we); // R8
  AST_ERR_STICKY:  assert property (@(posedge clk) disable iff (rst) err |=> err); // R9
endmodule

bind cfgprog_port cfgprog_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk (clk), .rst (rst), .busy (busy), .err (err), .fl_we (fl_we),
  .frm_vld (frm_vld), .wr_req (wr_req), .mem_we (mem_we), .cfg_open (cfg_open)
);

// File: tb/sim_cfgprog_port.sv
module sim_cfgprog_port;
  localparam int CLK_PERIOD = 10;
  localparam int NC   = 16;
  localparam int PCYC = 150;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pgc = 1'b0;
  logic        pgd = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [21:0] ptr;
  logic        busy, err, fl_we;
  logic [8:0]  fl_addr;
  logic [15:0] fl_data;

  cfgprog_port #(.NCFG(NC), .PROG_CYC(PCYC)) u0 (
    .clk, .rst, .pgc, .pgd, .rd_addr, .rd_data, .ptr,
    .busy, .err, .fl_we, .fl_addr, .fl_data
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  m_cfg [NC];
  logic [21:0] m_ptr;
  logic [7:0]  m_w;
  logic        m_err;
  int cur_len = 0, last_len = 0, fl_cnt = 0;
  logic [8:0]  fl_a;
  logic [15:0] fl_d;

  always @(negedge clk) begin
    if (busy) cur_len++;
    else if (cur_len != 0) begin last_len = cur_len; cur_len = 0; end
    if (fl_we) begin fl_cnt++; fl_a = fl_addr; fl_d = fl_data; end
  end

  function automatic logic [7:0] pick(input logic [21:0] a, input logic [15:0] p);
    return a[0] ? p[15:8] : p[7:0];
  endfunction

  function automatic logic [21:0] ptr_step(input logic [21:0] a, input logic [15:0] p,
                                           inout logic [7:0] w);
    logic [21:0] r = a;
    if (p[15:8] == 8'h0E) w = p[7:0];
    else if (p[15:8] == 8'h6E) begin
      if (p[7:0] == 8'hF8) r[21:16] = w[5:0];
      else if (p[7:0] == 8'hF7) r[15:8] = w;
      else if (p[7:0] == 8'hF6) r[7:0] = w;
    end else if (p == 16'h2AF6) r[7:0] = a[7:0] + 8'd1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NC; i++) m_cfg[i] = 8'hFF;
    m_ptr = '0; m_w = '0; m_err = 1'b0; fl_cnt = 0;
    @(negedge clk);
  endtask

  task automatic send(input logic [3:0] cmd, input logic [15:0] pay);
    logic [19:0] d = {pay, cmd};
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      pgd = d[i];
      pgc = 1'b1;
      repeat (HALF) @(negedge clk);
      pgc = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic core(input logic [15:0] pay);
    send(4'b0000, pay);
    m_ptr = ptr_step(m_ptr, pay, m_w);
  endtask

  task automatic set_ptr(input logic [21:0] a);
    core({8'h0E, 2'b00, a[21:16]}); core(16'h6EF8);
    core({8'h0E, a[15:8]});         core(16'h6EF7);
    core({8'h0E, a[7:0]});          core(16'h6EF6);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * PCYC && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // table write from idle; model follows the requirements
  task automatic tblwr(input logic [15:0] pay);
    logic [21:0] off = m_ptr - 22'h300000;
    send(4'b1111, pay);
    if (off < NC) begin
      if (m_cfg[11][5]) m_cfg[off[3:0]] = pick(m_ptr, pay);
    end else if (m_ptr <= 22'h0001FF) begin
      if (!m_cfg[11][6]) m_err = 1'b1;
    end else m_err = 1'b1;
  endtask

  task automatic rd(input int idx, output logic [7:0] v);
    @(negedge clk);
    rd_addr = idx[3:0];
    repeat (2) @(negedge clk);
    v = rd_data;
  endtask

  task automatic chk_all(input string tag);
    logic [7:0] v;
    for (int i = 0; i < NC; i++) begin
      rd(i, v);
      chk(tag, {24'd0, v}, {24'd0, m_cfg[i]});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    do_reset();

    // R9 reset state
    chk("R9 busy", {31'd0, busy}, 32'd0);
    chk("R9 err", {31'd0, err}, 32'd0);
    chk("R9 ptr", {10'd0, ptr}, 32'd0);
    chk_all("R9 cfg erased");

    // R1 R2 pointer loading through serial frames
    set_ptr(22'h300002);
    chk("R1 R2 ptr load", {10'd0, ptr}, {10'd0, m_ptr});
    set_ptr(22'h1234FF);
    core(16'h2AF6);
    chk("R2 inc wrap", {10'd0, ptr}, 32'h00123400);
    core(16'h6E00);
    core(16'h1234);
    chk("R2 no-op", {10'd0, ptr}, 32'h00123400);

    // R3 parity steering
    set_ptr(22'h300002);
    tblwr(16'hA55A);
    chk("R5 busy after write", {31'd0, busy}, 32'd1);
    wait_idle();
    chk("R5 busy length", last_len, PCYC);
    core(16'h2AF6);
    tblwr(16'h3CC3);
    wait_idle();
    rd(2, v); chk("R3 even low byte", {24'd0, v}, 32'h5A);
    rd(3, v); chk("R3 odd high byte", {24'd0, v}, 32'h3C);
    chk_all("R3 others unchanged");
    chk("R3 no err", {31'd0, err}, 32'd0);

    // R4 outside both ranges
    set_ptr(22'h300010);
    tblwr(16'h0000);
    chk("R4 err past cfg", {31'd0, err}, 32'd1);
    chk("R4 no busy", {31'd0, busy}, 32'd0);
    chk_all("R4 cfg unchanged");

    // R8 boot window open
    do_reset();
    set_ptr(22'h000100);
    tblwr(16'hBEEF);
    wait_idle();
    chk("R8 strobe count", fl_cnt, 1);
    chk("R8 strobe addr", {23'd0, fl_a}, 32'h100);
    chk("R8 strobe data", {16'd0, fl_d}, 32'hBEEF);
    chk("R8 no err", {31'd0, err}, 32'd0);
    chk("R5 boot busy length", last_len, PCYC);
    set_ptr(22'h000200);
    tblwr(16'h1111);
    chk("R4 just past boot", {31'd0, err}, 32'd1);
    chk("R4 no strobe", fl_cnt, 1);

    // R8 boot window locked
    do_reset();
    set_ptr(22'h30000B);
    tblwr(16'hBF00);
    wait_idle();
    set_ptr(22'h0001FF);
    tblwr(16'h2222);
    chk("R8 locked err", {31'd0, err}, 32'd1);
    chk("R8 locked no strobe", fl_cnt, 0);

    // R7 configuration self-lock
    do_reset();
    set_ptr(22'h30000B);
    tblwr(16'hDF00);
    wait_idle();
    set_ptr(22'h300000);
    tblwr(16'h0012);
    chk("R7 busy while locked", {31'd0, busy}, 32'd1);
    wait_idle();
    set_ptr(22'h30000B);
    tblwr(16'hFF00);
    wait_idle();
    chk("R7 no err", {31'd0, err}, 32'd0);
    chk_all("R7 locked array");

    // R6 write while busy
    do_reset();
    set_ptr(22'h300004);
    tblwr(16'h0077);
    send(4'b1111, 16'h0099);
    chk("R6 err on drop", {31'd0, err}, 32'd1);
    wait_idle();
    chk_all("R6 dropped write");

    // random table writes, R2 R3
    do_reset();
    for (int it = 0; it < 40; it++) begin
      int idx = int'($urandom % NC);
      logic [15:0] p = 16'($urandom);
      if (idx == 11) idx = 12;
      set_ptr(22'h300000 + 22'(idx));
      if ($urandom % 3 == 0) core(16'($urandom));
      chk("R2 random ptr", {10'd0, ptr}, {10'd0, m_ptr});
      tblwr(p);
      wait_idle();
      if (m_ptr >= 22'h300000 && m_ptr < 22'h300000 + NC) begin
        rd(int'(m_ptr[3:0]), v);
        chk("R3 random byte", {24'd0, v}, {24'd0, m_cfg[m_ptr[3:0]]});
      end
      chk("R4 random err", {31'd0, err}, {31'd0, m_err});
    end
    chk_all("R3 random array");

    summary();
    $finish;
  end
endmodule